// File: doc/BRIEF.md
# Serial-Controlled 16-Pin GPIO Expander

This block is the device side of a four-wire serial link that exposes sixteen general-purpose pins as two 8-bit ports. Port A holds pins 0 to 7 and port B holds pins 8 to 15. A host opens a transaction by pulling chip select low. It then shifts in a control byte that selects this device and the transfer direction, followed by a register address and any number of data bytes. Internally the block keeps a byte-addressed register file. The registers cover pin direction, input inversion, change-interrupt enable, compare value and compare mode, a shared configuration byte, pull-up enables, latched interrupt flags, an interrupt snapshot, the live port and the output latch.

Each register comes as a port A / port B pair: an even address for A and the next odd address for B. Because the address advances after every data byte, one transaction with two data bytes moves a full 16-bit value, with A first and B second. The serial inputs and the pad inputs are brought into the system clock through synchronizer flops, so the system clock must run at least four times faster than the serial clock. The pins drive pad outputs, per-pin output enables and pull-up requests.

Top module: `spi_gpio_expander`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all pins are inputs (`pad_oe` = 0). In that state `pad_out` = 0, `pad_pullup` = 0 and `spi_miso_oe` = 0. Reading the direction pair then returns 0xFFFF, and every other register reads 0.
- R2: The first byte of a transaction is the control byte. Its bits 7:4 must equal 4'b0100 and its bits 3:1 must equal `dev_addr`. Bit 0 = 1 selects a read and bit 0 = 0 selects a write. If the byte does not match, the rest of the transaction is ignored: no register changes and `spi_miso_oe` stays 0.
- R3: The second byte is the register address, and only its bits 4:0 are decoded. After each data byte the address advances by one and wraps from 0x1F to 0x00. A transfer that starts on an even address carries A then B; one that starts on an odd address carries B and then the next pair's A.
- R4: The link uses serial mode 0, most significant bit first. The device samples `spi_mosi` on the rising `spi_sck` edge and updates `spi_miso` after the falling edge. `spi_miso_oe` is 1 only during the data bytes of a matched read and is 0 during the control and address bytes and during writes.
- R5: The direction pair sits at 0x00/0x01. A bit value of 1 makes the pin an input and 0 makes it an output, so `pad_oe[i]` is the inverse of direction bit i. Even addresses map to pins 7:0 and odd addresses to pins 15:8.
- R6: A write to the port pair (0x12/0x13) or to the latch pair (0x14/0x15) updates the output latch, which drives `pad_out`. Reading the latch pair returns the latched values without sampling the pins.
- R7: Reading the port pair returns the synchronized `pad_in` value XOR the inversion pair (0x02/0x03).
- R8: Writes to the flag pair (0x0E/0x0F), the snapshot pair (0x10/0x11) and any address above 0x15 have no effect. Reads of addresses above 0x15 return 0.
- R9: The configuration byte is a single register that appears at both 0x0A and 0x0B.
- R10: Each pin has a change-detection source value: the synchronized pin XOR its inversion bit. For an enabled pin (0x04/0x05), the flag bit (0x0E/0x0F) sets when this value differs from the compare value (0x06/0x07) if the mode bit (0x08/0x09) is 1, or from its value in the previous cycle if the mode bit is 0. A port's snapshot (0x10/0x11) captures its source value when that port's flags go from all clear to some set. Reading the first bit of that port's port or snapshot byte clears its flags. Flags are sticky otherwise.
- R11: Raising `spi_cs_n` ends the transaction at once. A partly received byte is discarded, and the next transaction starts again with a control byte.
- R12: The pull-up pair (0x0C/0x0D) reads back as written and drives `pad_pullup`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_addr | input | 3 | Device select value compared with control bits 3:1 |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso`; 0 means high impedance |
| pad_in | input | 16 | Pin levels, port A in bits 7:0 |
| pad_out | output | 16 | Output latch value per pin |
| pad_oe | output | 16 | Per-pin output enable |
| pad_pullup | output | 16 | Per-pin pull-up request |

## Verification
The bench uses the default two-stage synchronizer, ties `dev_addr` to 3'b101 and runs the serial clock at one eighth of the system clock. With that four-cycle half period, each edge arrives after the three-cycle synchronize-and-detect delay, so the first read bit is valid when the host samples it. Using an address other than zero means a wrong device select or a wrong fixed nibble can be sent and shown to be rejected. The change-detection tests rely on the two pad-input flops to see a one-cycle change in previous-value mode. They also show that the snapshot stays frozen while a port's flags are already set.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W   = 8;
    localparam int NPORT    = 2;
    localparam int PORT_W   = BYTE_W;
    localparam int PIN_W    = PORT_W * NPORT;
    localparam int RADDR_W  = 5;
    localparam int DEVADR_W = 3;
    localparam int PBASE_W  = $clog2(PIN_W);

    localparam logic [3:0]         CTRL_TAG = 4'b0100;
    localparam logic [RADDR_W-1:0] LAST_REG = 5'h15;

    // register pair index = address bits 4:1
    typedef enum logic [3:0] {
        G_DIR  = 4'd0,
        G_POL  = 4'd1,
        G_IEN  = 4'd2,
        G_DEF  = 4'd3,
        G_MODE = 4'd4,
        G_CFG  = 4'd5,
        G_PULL = 4'd6,
        G_FLAG = 4'd7,
        G_CAP  = 4'd8,
        G_PORT = 4'd9,
        G_LAT  = 4'd10
    } grp_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic                en;
        logic [RADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]   data;
    } wr_req_t;

    function automatic logic ctrl_hit(input logic [BYTE_W-1:0] b,
                                      input logic [DEVADR_W-1:0] dev);
        return (b[7:4] == CTRL_TAG) && (b[3:1] == dev);
    endfunction

    function automatic grp_e addr_group(input logic [RADDR_W-1:0] a);
        return grp_e'(a[RADDR_W-1:1]);
    endfunction

    function automatic logic [PBASE_W-1:0] half_base(input logic odd);
        return odd ? PBASE_W'(PORT_W) : '0;
    endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int         W      = 1,
    parameter int         STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_spi_link.sv
module gpx_spi_link
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              cs_act,
    output logic              byte_done,
    output logic              msb_rise,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CW = $clog2(BYTE_W);

    logic              sck_d;
    logic [CW-1:0]     bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rise, fall;

    assign cs_act    = ~cs_n_s;
    assign rise      = cs_act &  sck_s & ~sck_d;
    assign fall      = cs_act & ~sck_s &  sck_d;
    assign byte_done = rise && (bit_cnt == CW'(BYTE_W-1));
    assign msb_rise  = rise && (bit_cnt == '0);
    assign rx_byte   = {rx_sh, mosi_s};
    assign miso      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // counters and shifters clear whenever select is released
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            if (rise) begin
                rx_sh   <= rx_byte[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall) begin
                // falling edge that opens a new byte loads it, others shift
                tx_sh <= (bit_cnt == '0) ? tx_byte : {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  wr_req_t            wr,
    input  logic [RADDR_W-1:0] rd_addr,
    input  logic               rd_touch,
    input  logic [PIN_W-1:0]   pins_s,
    output logic [BYTE_W-1:0]  rd_data,
    output logic [PIN_W-1:0]   dir_o,
    output logic [PIN_W-1:0]   lat_o,
    output logic [PIN_W-1:0]   pull_o,
    output logic [PIN_W-1:0]   flag_o,
    output logic [PIN_W-1:0]   ien_o
);
    logic [PIN_W-1:0]   dir_q, pol_q, ien_q, def_q, mode_q, pull_q, lat_q;
    logic [PIN_W-1:0]   flag_q, cap_q, prev_q;
    logic [BYTE_W-1:0]  cfg_q;
    logic [PIN_W-1:0]   src_v, ref_v, hit, flag_kept;
    logic [NPORT-1:0]   clr_port, cap_take;
    logic [PBASE_W-1:0] wbase, rbase;
    logic               wr_ok, rd_ok, rd_clears;
    grp_e               wgrp, rgrp;

    assign wr_ok     = wr.en && (wr.addr <= LAST_REG);
    assign rd_ok     = rd_addr <= LAST_REG;
    assign wgrp      = addr_group(wr.addr);
    assign rgrp      = addr_group(rd_addr);
    assign wbase     = half_base(wr.addr[0]);
    assign rbase     = half_base(rd_addr[0]);
    assign rd_clears = rd_touch && rd_ok && (rgrp == G_PORT || rgrp == G_CAP);

    // change detection
    assign src_v = pins_s ^ pol_q;
    assign ref_v = (mode_q & def_q) | (~mode_q & prev_q);
    assign hit   = ien_q & (src_v ^ ref_v);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int LO = p * PORT_W;
        assign clr_port[p] = rd_clears && (rd_addr[0] == 1'(p));
        assign flag_kept[LO +: PORT_W] = clr_port[p] ? '0 : flag_q[LO +: PORT_W];
        assign cap_take[p] = (flag_kept[LO +: PORT_W] == '0) && (hit[LO +: PORT_W] != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            pol_q  <= '0;
            ien_q  <= '0;
            def_q  <= '0;
            mode_q <= '0;
            pull_q <= '0;
            lat_q  <= '0;
            cfg_q  <= '0;
        end else if (wr_ok) begin
            case (wgrp)
                G_DIR:         dir_q[wbase +: PORT_W]  <= wr.data;
                G_POL:         pol_q[wbase +: PORT_W]  <= wr.data;
                G_IEN:         ien_q[wbase +: PORT_W]  <= wr.data;
                G_DEF:         def_q[wbase +: PORT_W]  <= wr.data;
                G_MODE:        mode_q[wbase +: PORT_W] <= wr.data;
                G_CFG:         cfg_q                   <= wr.data;
                G_PULL:        pull_q[wbase +: PORT_W] <= wr.data;
                G_PORT, G_LAT: lat_q[wbase +: PORT_W]  <= wr.data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            cap_q  <= '0;
            prev_q <= '0;
        end else begin
            flag_q <= flag_kept | hit;
            prev_q <= src_v;
            for (int p = 0; p < NPORT; p++) begin
                if (cap_take[p]) cap_q[p*PORT_W +: PORT_W] <= src_v[p*PORT_W +: PORT_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            case (rgrp)
                G_DIR:  rd_data = dir_q[rbase +: PORT_W];
                G_POL:  rd_data = pol_q[rbase +: PORT_W];
                G_IEN:  rd_data = ien_q[rbase +: PORT_W];
                G_DEF:  rd_data = def_q[rbase +: PORT_W];
                G_MODE: rd_data = mode_q[rbase +: PORT_W];
                G_CFG:  rd_data = cfg_q;
                G_PULL: rd_data = pull_q[rbase +: PORT_W];
                G_FLAG: rd_data = flag_q[rbase +: PORT_W];
                G_CAP:  rd_data = cap_q[rbase +: PORT_W];
                G_PORT: rd_data = src_v[rbase +: PORT_W];
                G_LAT:  rd_data = lat_q[rbase +: PORT_W];
                default: rd_data = '0;
            endcase
        end
    end

    assign dir_o  = dir_q;
    assign lat_o  = lat_q;
    assign pull_o = pull_q;
    assign flag_o = flag_q;
    assign ien_o  = ien_q;
endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
    import gpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DEVADR_W-1:0] dev_addr,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    output logic                spi_miso_oe,
    input  logic [PIN_W-1:0]    pad_in,
    output logic [PIN_W-1:0]    pad_out,
    output logic [PIN_W-1:0]    pad_oe,
    output logic [PIN_W-1:0]    pad_pullup
);
    logic [2:0]         line_s;
    logic [PIN_W-1:0]   pins_s;
    logic               cs_act, byte_done, msb_rise, link_miso;
    logic [BYTE_W-1:0]  rx_byte, rd_data;
    phase_e             phase;
    logic               is_read;
    logic [RADDR_W-1:0] ptr;
    wr_req_t            wr_req;
    logic               wr_en, rd_touch;
    logic [PIN_W-1:0]   dir_vec, flag_vec, ien_vec;

    gpx_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_line_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_cs_n, spi_mosi}),
        .q(line_s)
    );

    gpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .INIT('0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_s)
    );

    gpx_spi_link u_link (
        .clk(clk), .rst_n(rst_n),
        .sck_s(line_s[2]), .cs_n_s(line_s[1]), .mosi_s(line_s[0]),
        .tx_byte(rd_data),
        .cs_act(cs_act), .byte_done(byte_done), .msb_rise(msb_rise),
        .rx_byte(rx_byte), .miso(link_miso)
    );

    // transaction sequencing: control, address, then data bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CTRL;
            is_read <= 1'b0;
            ptr     <= '0;
        end else if (!cs_act) begin
            phase   <= PH_CTRL;
            is_read <= 1'b0;
        end else if (byte_done) begin
            case (phase)
                PH_CTRL: begin
                    phase   <= ctrl_hit(rx_byte, dev_addr) ? PH_ADDR : PH_SKIP;
                    is_read <= rx_byte[0];
                end
                PH_ADDR: begin
                    ptr   <= rx_byte[RADDR_W-1:0];
                    phase <= PH_DATA;
                end
                PH_DATA: ptr <= ptr + 1'b1;
                default: ;
            endcase
        end
    end

    assign wr_en       = byte_done && (phase == PH_DATA) && !is_read;
    assign wr_req.en   = wr_en;
    assign wr_req.addr = ptr;
    assign wr_req.data = rx_byte;
    assign rd_touch    = msb_rise && (phase == PH_DATA) && is_read;

    gpx_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_req), .rd_addr(ptr), .rd_touch(rd_touch), .pins_s(pins_s),
        .rd_data(rd_data),
        .dir_o(dir_vec), .lat_o(pad_out), .pull_o(pad_pullup),
        .flag_o(flag_vec), .ien_o(ien_vec)
    );

    assign pad_oe      = ~dir_vec;
    assign spi_miso_oe = cs_act && (phase == PH_DATA) && is_read;
    assign spi_miso    = spi_miso_oe ? link_miso : 1'b0;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cs_act,
    input logic               spi_miso_oe,
    input phase_e             phase,
    input logic               is_read,
    input logic               byte_done,
    input logic [RADDR_W-1:0] ptr,
    input logic [PIN_W-1:0]   flags,
    input logic [PIN_W-1:0]   ien,
    input logic [PIN_W-1:0]   pad_out,
    input logic [PIN_W-1:0]   pad_oe,
    input logic               wr_en
);
    p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && !spi_miso_oe));

    p_drive_read_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (phase == PH_DATA && is_read));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !spi_miso_oe);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cs_act && phase == PH_DATA) |=> (ptr == $past(ptr) + 1'b1));

    p_flag_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(ien)) == '0);

    p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(pad_out));
endmodule

bind spi_gpio_expander gpx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .spi_miso_oe(spi_miso_oe),
    .phase(phase), .is_read(is_read), .byte_done(byte_done), .ptr(ptr),
    .flags(flag_vec), .ien(ien_vec), .pad_out(pad_out), .pad_oe(pad_oe),
    .wr_en(wr_en)
);

// File: tb/spi_gpio_expander_tb.sv
module spi_gpio_expander_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam logic [7:0] CW_WR = 8'h4A;  // dev 3'b101, write
    localparam logic [7:0] CW_RD = 8'h4B;  // dev 3'b101, read

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [15:0] dat;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 16'hFFFF, "R1"},
        '{1'b0, 8'h00, 16'hFF00, "R5"},
        '{1'b1, 8'h00, 16'hFF00, "R5"},
        '{1'b0, 8'h12, 16'h00A5, "R6"},
        '{1'b1, 8'h14, 16'h00A5, "R6"},
        '{1'b0, 8'h15, 16'h12C3, "R3"},
        '{1'b1, 8'h14, 16'hC3A5, "R3"},
        '{1'b0, 8'h0A, 16'h2211, "R9"},
        '{1'b1, 8'h0A, 16'h2222, "R9"},
        '{1'b0, 8'h0C, 16'h8001, "R12"},
        '{1'b1, 8'h0C, 16'h8001, "R12"},
        '{1'b0, 8'h0E, 16'hFFFF, "R8"},
        '{1'b1, 8'h0E, 16'h0000, "R8"},
        '{1'b0, 8'h10, 16'hFFFF, "R8"},
        '{1'b1, 8'h10, 16'h0000, "R8"},
        '{1'b0, 8'h16, 16'h1234, "R8"},
        '{1'b1, 8'h15, 16'h00C3, "R8"},
        '{1'b0, 8'h02, 16'h0F0F, "R7"},
        '{1'b1, 8'h12, 16'h5533, "R7"},
        '{1'b1, 8'h01, 16'h0FFF, "R3"},
        '{1'b0, 8'h1F, 16'h3300, "R3"}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  dev_addr = 3'b101;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [15:0] pad_in = 16'h0000;
    logic [15:0] pad_out, pad_oe, pad_pullup;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_gpio_expander u_dut (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [23:0] tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits,
                            output logic [7:0] rx, output logic oe_any);
        rx = '0;
        oe_any = 1'b0;
        for (int b = 7; b > 7 - nbits; b--) begin
            spi_mosi = tx[b];
            tick(HALF);
            rx[b] = spi_miso;
            oe_any = oe_any | spi_miso_oe;
            spi_sck = 1'b1;
            tick(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] ctrl, input logic [7:0] addr,
                        input logic [7:0] d0, input logic [7:0] d1,
                        output logic [15:0] rd, output logic oe_hdr, output logic oe_dat);
        logic [7:0] r0, r1, rx;
        logic o0, o1, o2, o3;
        spi_cs_n = 1'b0;
        tick(HALF);
        spi_bits(ctrl, 8, rx, o0);
        spi_bits(addr, 8, rx, o1);
        spi_bits(d0, 8, r0, o2);
        spi_bits(d1, 8, r1, o3);
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(3*HALF);
        rd = {r1, r0};
        oe_hdr = o0 | o1;
        oe_dat = o2 & o3;
    endtask

    task automatic wr16(input logic [7:0] addr, input logic [15:0] v);
        logic [15:0] rd;
        logic oh, od;
        xfer(CW_WR, addr, v[7:0], v[15:8], rd, oh, od);
    endtask

    task automatic rd16(input logic [7:0] addr, output logic [15:0] v);
        logic oh, od;
        xfer(CW_RD, addr, 8'h00, 8'h00, v, oh, od);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic oh, od, ox, o_ab;
        logic [7:0] rx;

        tick(5);
        // R1: state while and just after reset
        check("R1", pad_oe, 16'h0000);
        check("R1", {15'b0, spi_miso_oe}, 16'h0000);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", pad_oe, 16'h0000);
        check("R1", pad_out, 16'h0000);
        check("R1", pad_pullup, 16'h0000);
        tick(4);

        pad_in = 16'h5A3C;
        tick(4);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                xfer(CW_RD, VECS[i].addr, 8'h00, 8'h00, rd, oh, od);
                check(VECS[i].tag, rd, VECS[i].dat);
                check("R4", {14'b0, oh, od}, 16'h0001);
            end else begin
                xfer(CW_WR, VECS[i].addr, VECS[i].dat[7:0], VECS[i].dat[15:8], rd, oh, od);
                check("R4", {14'b0, oh, od}, 16'h0000);
            end
        end

        // R3: write starting at 0x1F wrapped into direction A
        rd16(8'h00, rd);
        check("R3", rd, 16'hFF33);
        check("R5", pad_oe, 16'h00CC);
        check("R6", pad_out, 16'hC3A5);
        check("R12", pad_pullup, 16'h8001);

        // R2: wrong device select and wrong fixed nibble are ignored
        xfer(8'h48, 8'h14, 8'hFF, 8'hFF, rd, oh, od);
        check("R2", pad_out, 16'hC3A5);
        xfer(8'h5A, 8'h14, 8'hFF, 8'hFF, rd, oh, od);
        check("R2", pad_out, 16'hC3A5);
        xfer(8'h49, 8'h14, 8'h00, 8'h00, rd, oh, od);
        check("R2", {14'b0, oh, od}, 16'h0000);

        // R11: abort in the middle of a data byte, then a clean write
        spi_cs_n = 1'b0;
        tick(HALF);
        spi_bits(CW_WR, 8, rx, ox);
        spi_bits(8'h14, 8, rx, ox);
        spi_bits(8'h00, 4, rx, ox);
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(3*HALF);
        check("R11", pad_out, 16'hC3A5);
        spi_cs_n = 1'b0;
        tick(HALF);
        spi_bits(CW_WR, 3, rx, ox);
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(3*HALF);
        wr16(8'h14, 16'h6F5E);
        check("R11", pad_out, 16'h6F5E);

        // R1: reset from a busy state
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", pad_oe, 16'h0000);
        check("R1", pad_out, 16'h0000);
        check("R1", pad_pullup, 16'h0000);
        tick(4);
        rd16(8'h00, rd);
        check("R1", rd, 16'hFFFF);
        rd16(8'h02, rd);
        check("R1", rd, 16'h0000);

        // R10: change detection
        pad_in = 16'h0000;
        tick(6);
        wr16(8'h04, 16'h0003);
        wr16(8'h08, 16'h0001);
        wr16(8'h06, 16'h0000);
        pad_in = 16'h0005;
        tick(6);
        rd16(8'h0E, rd);
        check("R10", rd, 16'h0001);
        rd16(8'h10, rd);
        check("R10", rd, 16'h0005);
        pad_in = 16'h0004;
        tick(6);
        rd16(8'h12, rd);
        check("R10", rd, 16'h0004);
        rd16(8'h0E, rd);
        check("R10", rd, 16'h0000);
        pad_in = 16'h0006;
        tick(6);
        rd16(8'h0E, rd);
        check("R10", rd, 16'h0002);
        pad_in = 16'h0007;
        tick(6);
        rd16(8'h0E, rd);
        check("R10", rd, 16'h0003);
        rd16(8'h10, rd);
        check("R10", rd, 16'h0006);

        o_ab = spi_miso_oe;
        check("R4", {15'b0, o_ab}, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule